// File: doc/BRIEF.md
# Half-Bridge Switch Fault Detector

This block watches every power switch of a set of half-bridge legs and decides, from logic-level signals only, whether a switch has failed shorted or failed open. Each leg has an upper and a lower switch. For each switch the block receives its gate command, the current comparator flag (set only by current in the transistor itself, never by its antiparallel diode) and the saturation-voltage comparator flag. The gate command of the other switch in the leg is taken from the same leg inputs. The block latches one short flag and one open flag per switch. It also records which leg and which side failed first, so that a reconfiguration controller can swap a spare leg in for the failed one.

A short is judged by comparing a switch's current flag with the gate command of its complementary switch. When the partner is commanded on, the switch under test must be off, so current through it is a fault. Its own gate command is not used. This keeps the check insensitive to load level, to the DC-link voltage and to the switch's own turn-off delay. An open is judged when a switch is commanded on but still shows high collector-emitter voltage. A programmable blanking interval after turn-on masks the normal voltage fall. A programmable qualification count rejects single-sample glitches on the current flag. All pins are plain control and status signals: the block accepts no stream and sends none, so it has no handshake and no back-pressure.

Top module: `fd_power_fault_top`

## Requirements
- R1: After reset every short and open flag is 0 and fault_valid is 0.
- R2: The short flag of the upper switch of leg i (short_hi[i]) sets when ioc_hi[i] and gate_lo[i] are both high on cfg_qual+1 consecutive clock edges, and is visible after the last of those edges. The lower switch follows the mirror rule, with ioc_lo[i] and gate_hi[i] setting short_lo[i].
- R3: A run of cfg_qual or fewer qualifying edges leaves the short flag at 0, and a run broken by one non-qualifying edge restarts the count.
- R4: A switch's own gate command never qualifies its short check. Current flagged while the complementary gate is low sets no short flag, whatever the own gate is.
- R5: open_hi[i] (or open_lo[i]) sets on an edge where the switch's gate is high, its vsat flag is high and leg_en[i] is high, once that edge is at least the (cfg_blank+1)-th consecutive edge with the gate high and the leg enabled. Earlier edges of that run are masked.
- R6: While leg_en[i] is low, neither open flag of leg i can set. Disabling the leg restarts its blanking, so after re-enable the full blanking interval applies again.
- R7: Flags stay set until clear. On the edge where clear is high, all flags and the report drop to 0 and any detection on that edge is discarded. Counters are not reset, so a condition still present re-latches on the following edge.
- R8: fault_valid, fault_leg, fault_lower (1 = lower switch) and fault_open (1 = open, 0 = short) describe the first fault latched since reset or clear. They stay unchanged until clear, and fault_valid is 1 exactly when some flag is set.
- R9: When several faults latch on the same edge, the report picks the lowest leg index, then the upper switch before the lower, then short before open.
- R10: All NLEG legs are identical and independent: bit i of each flag vector belongs to leg i only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Drops all latched flags and the report |
| cfg_qual | input | QW | Extra consecutive edges required before a short latches |
| cfg_blank | input | BW | Edges after turn-on during which the open check is masked |
| leg_en | input | NLEG | Per-leg gating enable; low masks the open checks |
| gate_hi | input | NLEG | Upper switch gate commands |
| gate_lo | input | NLEG | Lower switch gate commands |
| ioc_hi | input | NLEG | Upper switch current-over-threshold flags |
| ioc_lo | input | NLEG | Lower switch current-over-threshold flags |
| vsat_hi | input | NLEG | Upper switch high-voltage flags |
| vsat_lo | input | NLEG | Lower switch high-voltage flags |
| short_hi | output | NLEG | Latched upper short faults |
| short_lo | output | NLEG | Latched lower short faults |
| open_hi | output | NLEG | Latched upper open faults |
| open_lo | output | NLEG | Latched lower open faults |
| fault_valid | output | 1 | A first-fault report is held |
| fault_leg | output | LW | Leg index of the first fault |
| fault_lower | output | 1 | First fault was on the lower switch |
| fault_open | output | 1 | First fault was an open (0 = short) |

## Verification
A short and an open can latch on the same edge, in the same leg or in different legs. The report must then make one ranked choice while every flag involved still latches. The bench provokes this by setting qualification and blanking to zero and raising both gates of a leg together with its current and voltage flags. It judges the report against a ranking worked out from leg, side and kind. A second case puts an upper open beside a lower short in one leg, to show that side outranks kind. Clear falling on an edge where a detection also fires is the other collision. It is checked by holding a short condition through the clear and expecting the flag to come back one edge later.

// File: rtl/fd_pkg.sv
package fd_pkg;
  typedef enum logic {SIDE_UPPER = 1'b0, SIDE_LOWER = 1'b1} side_e;
  typedef enum logic {KIND_SHORT = 1'b0, KIND_OPEN = 1'b1} kind_e;
  localparam int unsigned EVT_PER_LEG = 4;
  function automatic int unsigned evt_slot(int unsigned leg, side_e side, kind_e kind);
    return leg * EVT_PER_LEG + 32'(side) * 2 + 32'(kind);
  endfunction
endpackage

// File: rtl/fd_switch_chk.sv
module fd_switch_chk #(
  parameter int QW = 3,
  parameter int BW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          gate_own,
  input  logic          gate_comp,
  input  logic          ioc,
  input  logic          vsat,
  input  logic          leg_en,
  input  logic [QW-1:0] cfg_qual,
  input  logic [BW-1:0] cfg_blank,
  output logic          short_flag,
  output logic          open_flag,
  output logic          short_new,
  output logic          open_new
);
  localparam logic [QW-1:0] QMAX = {QW{1'b1}};
  localparam logic [BW-1:0] BMAX = {BW{1'b1}};

  logic [QW-1:0] qual_cnt;
  logic [BW-1:0] blank_cnt;
  logic          short_cond, short_hit, armed, open_hit;

  assign short_cond = ioc & gate_comp;
  assign short_hit  = short_cond && (qual_cnt >= cfg_qual);
  assign armed      = gate_own & leg_en;
  assign open_hit   = armed && vsat && (blank_cnt >= cfg_blank);

  always_ff @(posedge clk) begin
    if (!rst_n)             qual_cnt <= '0;
    else if (!short_cond)   qual_cnt <= '0;
    else if (qual_cnt != QMAX) qual_cnt <= qual_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              blank_cnt <= '0;
    else if (!armed)         blank_cnt <= '0;
    else if (blank_cnt != BMAX) blank_cnt <= blank_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      short_flag <= 1'b0;
      open_flag  <= 1'b0;
    end else begin
      if (short_hit) short_flag <= 1'b1;
      if (open_hit)  open_flag  <= 1'b1;
    end
  end

  assign short_new = short_hit & ~short_flag & ~clear;
  assign open_new  = open_hit & ~open_flag & ~clear;

  AST_SHORT_NEEDS_PARTNER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_flag) |-> $past(ioc && gate_comp)); // R2
  AST_OWN_GATE_NO_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_comp && !short_flag) |=> !short_flag); // R4
  AST_OPEN_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_flag) |-> $past(leg_en && gate_own && vsat)); // R6
  AST_OPEN_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_own) && cfg_blank != '0) |=> !$rose(open_flag)); // R5
  AST_FLAG_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    ((short_flag || open_flag) && !clear) |=>
      (short_flag >= $past(short_flag)) && (open_flag >= $past(open_flag))); // R7
endmodule

// File: rtl/fd_leg.sv
module fd_leg #(
  parameter int QW = 3,
  parameter int BW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [QW-1:0] cfg_qual,
  input  logic [BW-1:0] cfg_blank,
  input  logic          leg_en,
  input  logic          gate_hi,
  input  logic          gate_lo,
  input  logic [1:0]    ioc,
  input  logic [1:0]    vsat,
  output logic [1:0]    short_flag,
  output logic [1:0]    open_flag,
  output logic [1:0]    short_new,
  output logic [1:0]    open_new
);
  logic [1:0] gates;
  assign gates = {gate_lo, gate_hi};

  for (genvar s = 0; s < 2; s++) begin : g_side
    fd_switch_chk #(.QW(QW), .BW(BW)) u_sw (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .gate_own(gates[s]), .gate_comp(gates[1-s]),
      .ioc(ioc[s]), .vsat(vsat[s]), .leg_en(leg_en),
      .cfg_qual(cfg_qual), .cfg_blank(cfg_blank),
      .short_flag(short_flag[s]), .open_flag(open_flag[s]),
      .short_new(short_new[s]), .open_new(open_new[s])
    );
  end
endmodule

// File: rtl/fd_report.sv
module fd_report #(
  parameter int NLEG = 7,
  parameter int LW   = 3,
  localparam int NEVT = NLEG * fd_pkg::EVT_PER_LEG
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic [NEVT-1:0] evt,
  output logic            fault_valid,
  output logic [LW-1:0]   fault_leg,
  output logic            fault_lower,
  output logic            fault_open
);
  logic          any_evt;
  logic [LW-1:0] pick_leg;
  logic          pick_lower, pick_open;

  always_comb begin
    any_evt    = 1'b0;
    pick_leg   = '0;
    pick_lower = 1'b0;
    pick_open  = 1'b0;
    for (int k = NEVT - 1; k >= 0; k--) begin
      if (evt[k]) begin
        any_evt    = 1'b1;
        pick_leg   = LW'(k / fd_pkg::EVT_PER_LEG);
        pick_lower = ((k % fd_pkg::EVT_PER_LEG) / 2) != 0;
        pick_open  = (k % 2) != 0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      fault_valid <= 1'b0;
      fault_leg   <= '0;
      fault_lower <= 1'b0;
      fault_open  <= 1'b0;
    end else if (!fault_valid && any_evt) begin
      fault_valid <= 1'b1;
      fault_leg   <= pick_leg;
      fault_lower <= pick_lower;
      fault_open  <= pick_open;
    end
  end

  AST_REPORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !clear) |=> fault_valid && $stable(fault_leg) &&
      $stable(fault_lower) && $stable(fault_open)); // R8
  AST_REPORT_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_valid) |-> $past(|evt)); // R8
endmodule

// File: rtl/fd_power_fault_top.sv
module fd_power_fault_top #(
  parameter int NLEG = 7,
  parameter int QW   = 3,
  parameter int BW   = 6,
  localparam int LW  = (NLEG > 1) ? $clog2(NLEG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic [QW-1:0]   cfg_qual,
  input  logic [BW-1:0]   cfg_blank,
  input  logic [NLEG-1:0] leg_en,
  input  logic [NLEG-1:0] gate_hi,
  input  logic [NLEG-1:0] gate_lo,
  input  logic [NLEG-1:0] ioc_hi,
  input  logic [NLEG-1:0] ioc_lo,
  input  logic [NLEG-1:0] vsat_hi,
  input  logic [NLEG-1:0] vsat_lo,
  output logic [NLEG-1:0] short_hi,
  output logic [NLEG-1:0] short_lo,
  output logic [NLEG-1:0] open_hi,
  output logic [NLEG-1:0] open_lo,
  output logic            fault_valid,
  output logic [LW-1:0]   fault_leg,
  output logic            fault_lower,
  output logic            fault_open
);
  import fd_pkg::*;
  localparam int NEVT = NLEG * EVT_PER_LEG;

  logic [NEVT-1:0] evt;

  for (genvar i = 0; i < NLEG; i++) begin : g_leg
    logic [1:0] sf, of, sn, on;
    fd_leg #(.QW(QW), .BW(BW)) u_leg (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .cfg_qual(cfg_qual), .cfg_blank(cfg_blank), .leg_en(leg_en[i]),
      .gate_hi(gate_hi[i]), .gate_lo(gate_lo[i]),
      .ioc({ioc_lo[i], ioc_hi[i]}), .vsat({vsat_lo[i], vsat_hi[i]}),
      .short_flag(sf), .open_flag(of), .short_new(sn), .open_new(on)
    );
    assign short_hi[i] = sf[0];
    assign short_lo[i] = sf[1];
    assign open_hi[i]  = of[0];
    assign open_lo[i]  = of[1];
    assign evt[evt_slot(i, SIDE_UPPER, KIND_SHORT)] = sn[0];
    assign evt[evt_slot(i, SIDE_UPPER, KIND_OPEN)]  = on[0];
    assign evt[evt_slot(i, SIDE_LOWER, KIND_SHORT)] = sn[1];
    assign evt[evt_slot(i, SIDE_LOWER, KIND_OPEN)]  = on[1];
  end

  fd_report #(.NLEG(NLEG), .LW(LW)) u_report (
    .clk(clk), .rst_n(rst_n), .clear(clear), .evt(evt),
    .fault_valid(fault_valid), .fault_leg(fault_leg),
    .fault_lower(fault_lower), .fault_open(fault_open)
  );

  AST_VALID_TRACKS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid == |{short_hi, short_lo, open_hi, open_lo}); // R8
  AST_CLEAR_DROPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !fault_valid && ({short_hi, short_lo, open_hi, open_lo} == '0)); // R7
endmodule

// File: tb/sim_fd_power_fault_top.sv
module sim_fd_power_fault_top;
  localparam int N = 7;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, clr;
  logic [2:0] q;
  logic [5:0] bl;
  logic [N-1:0] en, ghi, glo, ihi, ilo, vhi, vlo;
  logic [N-1:0] shi, slo, ohi, olo;
  logic fv, flow, fopen;
  logic [2:0] fleg;

  fd_power_fault_top #(.NLEG(N), .QW(3), .BW(6)) u0 (
    .clk(clk), .rst_n(rst_n), .clear(clr), .cfg_qual(q), .cfg_blank(bl),
    .leg_en(en), .gate_hi(ghi), .gate_lo(glo), .ioc_hi(ihi), .ioc_lo(ilo),
    .vsat_hi(vhi), .vsat_lo(vlo), .short_hi(shi), .short_lo(slo),
    .open_hi(ohi), .open_lo(olo), .fault_valid(fv), .fault_leg(fleg),
    .fault_lower(flow), .fault_open(fopen));

  int checks = 0, errors = 0;
  bit done = 0;
  int scnt [N][2];
  int bcnt [N][2];
  bit msf [N][2];
  bit mof [N][2];
  bit mv, mlow, mopen;
  int mleg;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++)
      for (int s = 0; s < 2; s++) begin
        scnt[i][s] = 0; bcnt[i][s] = 0; msf[i][s] = 0; mof[i][s] = 0;
      end
    mv = 0; mleg = 0; mlow = 0; mopen = 0;
  endtask

  // one clock edge of the requirement model, using current inputs
  task automatic model_edge();
    bit sh [N][2];
    bit oh [N][2];
    bit found = 0;
    for (int i = 0; i < N; i++)
      for (int s = 0; s < 2; s++) begin
        bit gown  = s ? glo[i] : ghi[i];
        bit gcomp = s ? ghi[i] : glo[i];
        bit cur   = s ? ilo[i] : ihi[i];
        bit vs    = s ? vlo[i] : vhi[i];
        bit sc    = cur & gcomp;
        bit ar    = gown & en[i];
        sh[i][s] = sc && (scnt[i][s] >= int'(q));
        oh[i][s] = ar && vs && (bcnt[i][s] >= int'(bl));
        scnt[i][s] = sc ? ((scnt[i][s] < 1000) ? scnt[i][s] + 1 : 1000) : 0;
        bcnt[i][s] = ar ? ((bcnt[i][s] < 1000) ? bcnt[i][s] + 1 : 1000) : 0;
      end
    if (clr) begin
      for (int i = 0; i < N; i++)
        for (int s = 0; s < 2; s++) begin msf[i][s] = 0; mof[i][s] = 0; end
      mv = 0; mleg = 0; mlow = 0; mopen = 0;
    end else begin
      for (int i = 0; i < N; i++)
        for (int s = 0; s < 2; s++)
          for (int k = 0; k < 2; k++) begin
            bit h = k ? oh[i][s] : sh[i][s];
            if (h && !found && !mv) begin
              found = 1; mleg = i; mlow = s[0]; mopen = k[0];
            end
          end
      for (int i = 0; i < N; i++)
        for (int s = 0; s < 2; s++) begin
          msf[i][s] = msf[i][s] | sh[i][s];
          mof[i][s] = mof[i][s] | oh[i][s];
        end
      if (found) mv = 1;
    end
  endtask

  task automatic step();
    logic [N-1:0] e_shi, e_slo, e_ohi, e_olo;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      e_shi[i] = msf[i][0]; e_slo[i] = msf[i][1];
      e_ohi[i] = mof[i][0]; e_olo[i] = mof[i][1];
    end
    chk("R10 flags", int'({shi, slo, ohi, olo}), int'({e_shi, e_slo, e_ohi, e_olo}));
    chk("R8 report", int'({fv, fleg, flow, fopen}),
        int'({mv, 3'(mleg), mlow, mopen}));
  endtask

  task automatic idle_inputs();
    ghi = '0; glo = '0; ihi = '0; ilo = '0; vhi = '0; vlo = '0; clr = 0;
  endtask

  task automatic do_clear();
    clr = 1; step(); clr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; idle_inputs(); en = '1; q = 3'd2; bl = 6'd3;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk("R1 flags after reset", int'({shi, slo, ohi, olo}), 0);
    chk("R1 valid after reset", int'(fv), 0);

    // R3 / R2: upper short of leg 2, qualification of 3 edges
    glo[2] = 1; ihi[2] = 1; step(); step();
    chk("R3 short run too short", int'(shi[2]), 0);
    ihi[2] = 0; step(); ihi[2] = 1; step(); step();
    chk("R3 broken run restarts", int'(shi[2]), 0);
    step();
    chk("R2 upper short latched", int'(shi[2]), 1);
    chk("R8 first leg", int'(fleg), 2);
    chk("R8 first side/kind", int'({flow, fopen}), 0);
    idle_inputs();

    // R4: current with partner gate low never counts
    ilo[4] = 1; repeat (10) step();
    chk("R4 own gate not qualifier", int'(slo[4]), 0);
    ghi[4] = 1; repeat (3) step();
    chk("R2 lower short mirror", int'(slo[4]), 1);
    chk("R8 report held", int'(fleg), 2);
    idle_inputs();

    // R7: clear while condition persists
    glo[2] = 1; ihi[2] = 1; repeat (4) step();
    clr = 1; step();
    chk("R7 clear drops flags", int'({shi, slo, ohi, olo}), 0);
    chk("R7 clear drops report", int'(fv), 0);
    clr = 0; step();
    chk("R7 re-latch after clear", int'(shi[2]), 1);
    idle_inputs(); do_clear();

    // R5: blanking of 3 edges on lower switch of leg 5
    glo[5] = 1; vlo[5] = 1; repeat (3) step();
    chk("R5 open masked in blanking", int'(olo[5]), 0);
    step();
    chk("R5 open after blanking", int'(olo[5]), 1);
    chk("R8 open report", int'({fleg, flow, fopen}), int'({3'd5, 1'b1, 1'b1}));
    idle_inputs(); do_clear();

    // R6: disabled leg ignores open; re-enable re-blanks
    en[1] = 0; ghi[1] = 1; vhi[1] = 1; repeat (10) step();
    chk("R6 disabled leg no open", int'(ohi[1]), 0);
    en[1] = 1; repeat (3) step();
    chk("R6 re-blank after enable", int'(ohi[1]), 0);
    step();
    chk("R6 open after re-enable", int'(ohi[1]), 1);
    idle_inputs(); do_clear();

    // R9: simultaneous detections, immediate config
    q = 0; bl = 0;
    ghi[3] = 1; glo[3] = 1; ihi[3] = 1; vhi[3] = 1; ghi[6] = 1; ilo[6] = 1;
    step();
    chk("R9 all latch together", int'({shi[3], ohi[3], slo[6]}), 7);
    chk("R9 lowest leg short first", int'({fleg, flow, fopen}), int'({3'd3, 1'b0, 1'b0}));
    idle_inputs(); do_clear();
    ghi[0] = 1; vhi[0] = 1; ilo[0] = 1; step();
    chk("R9 upper open beats lower short", int'({fleg, flow, fopen}), int'({3'd0, 1'b0, 1'b1}));
    chk("R10 both latched leg 0", int'({ohi[0], slo[0]}), 3);
    idle_inputs(); do_clear();

    // random phase
    for (int blk = 0; blk < 16; blk++) begin
      q = 3'($urandom_range(0, 4)); bl = 6'($urandom_range(0, 6));
      for (int c = 0; c < 250; c++) begin
        for (int i = 0; i < N; i++) begin
          ghi[i] = ($urandom_range(0, 2) == 0);
          glo[i] = ghi[i] ? ($urandom_range(0, 9) == 0) : ($urandom_range(0, 1) == 0);
          ihi[i] = ($urandom_range(0, 7) == 0);
          ilo[i] = ($urandom_range(0, 7) == 0);
          vhi[i] = ($urandom_range(0, 3) == 0);
          vlo[i] = ($urandom_range(0, 3) == 0);
          en[i]  = ($urandom_range(0, 9) != 0);
        end
        clr = ($urandom_range(0, 39) == 0);
        step();
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule